// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how a five-stage integer pipeline (fetch, decode, execute, memory, write-back) must react to dependences between instructions in flight. It looks at the source register numbers held in the fetch/decode and decode/execute pipeline registers and at the destination numbers and write flags held further down. From these it produces three things. First, a freeze of the program counter and the fetch/decode register when a load is followed at once by an instruction that reads the loaded register. Second, a select that turns the instruction entering the decode/execute register into a bubble. Third, one 2-bit operand-source select for each of the two ALU inputs.

Branches are predicted not-taken and resolve in the memory stage. When a branch there is taken, the unit squashes the three younger instructions: the one in fetch/decode, the one entering decode/execute and the one entering execute/memory. It also lets the PC load the target. The whole unit is combinational, so every output follows its inputs within the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: When `idex_mem_rd_i` is 1, `idex_rt_i` equals `ifid_rs_i` or `ifid_rt_i`, and `br_taken_i` is 0, the outputs are `pc_wr_en_o`=0, `ifid_wr_en_o`=0 and `idex_bubble_o`=1.
- R2: When neither the R1 condition nor `br_taken_i` holds, the outputs are `pc_wr_en_o`=1, `ifid_wr_en_o`=1, `idex_bubble_o`=0, `ifid_flush_o`=0 and `exmem_bubble_o`=0.
- R3: `fwd_a_sel_o` is 1 (take the execute/memory result) when `exmem_reg_wr_i` is 1, `exmem_rd_i` is nonzero and `exmem_rd_i` equals `idex_rs_i`.
- R4: Otherwise, `fwd_a_sel_o` is 2 (take the write-back value) when `memwb_reg_wr_i` is 1, `memwb_rd_i` is nonzero and `memwb_rd_i` equals `idex_rs_i`.
- R5: When both the R3 and R4 conditions match the same source, the select is 1, because the nearer stage holds the newer value.
- R6: A destination register number of 0 never produces a forward, whatever its write flag.
- R7: `fwd_b_sel_o` follows the rules of R3 to R6, applied to `idex_rt_i` in place of `idex_rs_i`.
- R8: When no forwarding rule matches, the select is 0 (use the register-file operand). The value 3 never appears.
- R9: When `br_taken_i` is 1, all of `ifid_flush_o`, `idex_bubble_o`, `exmem_bubble_o`, `pc_wr_en_o` and `ifid_wr_en_o` are 1, even if the R1 condition also holds.
- R10: For a load followed directly by an R-type instruction that reads the loaded register, the pipeline loses exactly one cycle. When the dependent instruction reaches the decode/execute register, its operand is taken from write-back (select 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs_i | input | REG_AW | First source register of the instruction in fetch/decode |
| ifid_rt_i | input | REG_AW | Second source register of the instruction in fetch/decode |
| idex_mem_rd_i | input | 1 | Instruction in decode/execute reads data memory (a load) |
| idex_rs_i | input | REG_AW | First source register in decode/execute |
| idex_rt_i | input | REG_AW | Second source register in decode/execute (load destination) |
| exmem_reg_wr_i | input | 1 | Instruction in execute/memory writes a register |
| exmem_rd_i | input | REG_AW | Destination register in execute/memory |
| memwb_reg_wr_i | input | 1 | Instruction in memory/write-back writes a register |
| memwb_rd_i | input | REG_AW | Destination register in memory/write-back |
| br_taken_i | input | 1 | Branch in the memory stage resolved as taken |
| pc_wr_en_o | output | 1 | Program counter may update |
| ifid_wr_en_o | output | 1 | Fetch/decode register may load |
| idex_bubble_o | output | 1 | Zero all control bits loaded into decode/execute |
| ifid_flush_o | output | 1 | Load a no-op into fetch/decode |
| exmem_bubble_o | output | 1 | Zero all control bits loaded into execute/memory |
| fwd_a_sel_o | output | 2 | ALU input A source: 0 register file, 1 execute/memory, 2 write-back |
| fwd_b_sel_o | output | 2 | ALU input B source, same encoding |

## Verification
The checker assumes that every input carries a defined 0 or 1. It also assumes that the register numbers in a bubble still arrive with their write and memory-read flags cleared, so the number fields of a bubble are never trusted. The stimulus draws register numbers from a narrow range, so that equal specifiers, matches on register 0 and double matches occur often. It sets the branch-taken input in about one cycle in eight, so that flushes coincide with stall conditions. A small pipeline model in the bench then replays a load followed by its dependent instruction and feeds the unit's outputs back into the model's registers.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // ALU operand source encoding
  typedef enum logic [1:0] {
    FWD_REGFILE = 2'd0,
    FWD_EXMEM   = 2'd1,
    FWD_MEMWB   = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int REG_AW = 5
) (
  input  logic              idex_mem_rd_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  output logic              lu_stall_o
);
  logic hit_rs, hit_rt;

  always_comb begin
    hit_rs     = (idex_rt_i == ifid_rs_i);
    hit_rt     = (idex_rt_i == ifid_rt_i);
    lu_stall_o = idex_mem_rd_i & (hit_rs | hit_rt);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              near_wr_i,
  input  logic [REG_AW-1:0] near_rd_i,
  input  logic              far_wr_i,
  input  logic [REG_AW-1:0] far_rd_i,
  output fwd_sel_e          sel_o
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic near_hit, far_hit;

  always_comb begin
    near_hit = near_wr_i & (near_rd_i != ZERO_REG) & (near_rd_i == src_i);
    far_hit  = far_wr_i  & (far_rd_i  != ZERO_REG) & (far_rd_i  == src_i);
    if (near_hit)      sel_o = FWD_EXMEM;
    else if (far_hit)  sel_o = FWD_MEMWB;
    else               sel_o = FWD_REGFILE;
  end
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic br_taken_i,
  input  logic lu_stall_i,
  output logic pc_wr_en_o,
  output logic ifid_wr_en_o,
  output logic idex_bubble_o,
  output logic ifid_flush_o,
  output logic exmem_bubble_o
);
  logic hold;

  always_comb begin
    // a taken branch outranks a load-use hold
    hold           = lu_stall_i & ~br_taken_i;
    pc_wr_en_o     = ~hold;
    ifid_wr_en_o   = ~hold;
    idex_bubble_o  = hold | br_taken_i;
    ifid_flush_o   = br_taken_i;
    exmem_bubble_o = br_taken_i;
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ifid_rs_i,
  input  logic [REG_AW-1:0] ifid_rt_i,
  input  logic              idex_mem_rd_i,
  input  logic [REG_AW-1:0] idex_rs_i,
  input  logic [REG_AW-1:0] idex_rt_i,
  input  logic              exmem_reg_wr_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              memwb_reg_wr_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              br_taken_i,
  output logic              pc_wr_en_o,
  output logic              ifid_wr_en_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o,
  output logic              exmem_bubble_o,
  output logic [1:0]        fwd_a_sel_o,
  output logic [1:0]        fwd_b_sel_o
);
  localparam int NUM_OPND = 2;

  logic              lu_stall;
  logic [REG_AW-1:0] opnd_src [NUM_OPND];
  fwd_sel_e          opnd_sel [NUM_OPND];

  assign opnd_src[0] = idex_rs_i;
  assign opnd_src[1] = idex_rt_i;

  hz_load_use #(.REG_AW(REG_AW)) u_load_use (
    .idex_mem_rd_i (idex_mem_rd_i),
    .idex_rt_i     (idex_rt_i),
    .ifid_rs_i     (ifid_rs_i),
    .ifid_rt_i     (ifid_rt_i),
    .lu_stall_o    (lu_stall)
  );

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    hz_fwd_pick #(.REG_AW(REG_AW)) u_pick (
      .src_i     (opnd_src[g]),
      .near_wr_i (exmem_reg_wr_i),
      .near_rd_i (exmem_rd_i),
      .far_wr_i  (memwb_reg_wr_i),
      .far_rd_i  (memwb_rd_i),
      .sel_o     (opnd_sel[g])
    );
  end

  assign fwd_a_sel_o = opnd_sel[0];
  assign fwd_b_sel_o = opnd_sel[1];

  hz_redirect u_redirect (
    .br_taken_i     (br_taken_i),
    .lu_stall_i     (lu_stall),
    .pc_wr_en_o     (pc_wr_en_o),
    .ifid_wr_en_o   (ifid_wr_en_o),
    .idex_bubble_o  (idex_bubble_o),
    .ifid_flush_o   (ifid_flush_o),
    .exmem_bubble_o (exmem_bubble_o)
  );
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ifid_rs_i,
  input logic [REG_AW-1:0] ifid_rt_i,
  input logic              idex_mem_rd_i,
  input logic [REG_AW-1:0] idex_rs_i,
  input logic [REG_AW-1:0] idex_rt_i,
  input logic              exmem_reg_wr_i,
  input logic [REG_AW-1:0] exmem_rd_i,
  input logic              memwb_reg_wr_i,
  input logic [REG_AW-1:0] memwb_rd_i,
  input logic              br_taken_i,
  input logic              pc_wr_en_o,
  input logic              ifid_wr_en_o,
  input logic              idex_bubble_o,
  input logic              ifid_flush_o,
  input logic              exmem_bubble_o,
  input logic [1:0]        fwd_a_sel_o,
  input logic [1:0]        fwd_b_sel_o
);
  always_comb begin
    if (idex_mem_rd_i && (idex_rt_i == ifid_rs_i || idex_rt_i == ifid_rt_i) && !br_taken_i)
      a_r1_hold_front: assert (!pc_wr_en_o && !ifid_wr_en_o && idex_bubble_o);
    a_r2_front_pair: assert (pc_wr_en_o == ifid_wr_en_o);
    if (exmem_reg_wr_i && exmem_rd_i != '0 && exmem_rd_i == idex_rs_i)
      a_r5_near_wins: assert (fwd_a_sel_o == 2'd1);
    if (fwd_a_sel_o != 2'd0)
      a_r6_no_zero_a: assert ((fwd_a_sel_o == 2'd1) ? (exmem_rd_i != '0 && exmem_reg_wr_i)
                                                   : (memwb_rd_i != '0 && memwb_reg_wr_i));
    if (fwd_b_sel_o != 2'd0)
      a_r7_b_source: assert ((fwd_b_sel_o == 2'd1) ? (exmem_rd_i == idex_rt_i)
                                                  : (memwb_rd_i == idex_rt_i));
    a_r8_sel_legal: assert (fwd_a_sel_o != 2'd3 && fwd_b_sel_o != 2'd3);
    if (br_taken_i)
      a_r9_squash: assert (ifid_flush_o && idex_bubble_o && exmem_bubble_o && pc_wr_en_o);
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .ifid_rs_i      (ifid_rs_i),
  .ifid_rt_i      (ifid_rt_i),
  .idex_mem_rd_i  (idex_mem_rd_i),
  .idex_rs_i      (idex_rs_i),
  .idex_rt_i      (idex_rt_i),
  .exmem_reg_wr_i (exmem_reg_wr_i),
  .exmem_rd_i     (exmem_rd_i),
  .memwb_reg_wr_i (memwb_reg_wr_i),
  .memwb_rd_i     (memwb_rd_i),
  .br_taken_i     (br_taken_i),
  .pc_wr_en_o     (pc_wr_en_o),
  .ifid_wr_en_o   (ifid_wr_en_o),
  .idex_bubble_o  (idex_bubble_o),
  .ifid_flush_o   (ifid_flush_o),
  .exmem_bubble_o (exmem_bubble_o),
  .fwd_a_sel_o    (fwd_a_sel_o),
  .fwd_b_sel_o    (fwd_b_sel_o)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] ifid_rs, ifid_rt, idex_rs, idex_rt, exmem_rd, memwb_rd;
  logic          idex_mem_rd, exmem_reg_wr, memwb_reg_wr, br_taken;
  logic          pc_wr_en, ifid_wr_en, idex_bubble, ifid_flush, exmem_bubble;
  logic [1:0]    fwd_a, fwd_b;

  hazard_ctrl #(.REG_AW(RW)) u_dut (
    .ifid_rs_i(ifid_rs), .ifid_rt_i(ifid_rt), .idex_mem_rd_i(idex_mem_rd),
    .idex_rs_i(idex_rs), .idex_rt_i(idex_rt), .exmem_reg_wr_i(exmem_reg_wr),
    .exmem_rd_i(exmem_rd), .memwb_reg_wr_i(memwb_reg_wr), .memwb_rd_i(memwb_rd),
    .br_taken_i(br_taken), .pc_wr_en_o(pc_wr_en), .ifid_wr_en_o(ifid_wr_en),
    .idex_bubble_o(idex_bubble), .ifid_flush_o(ifid_flush),
    .exmem_bubble_o(exmem_bubble), .fwd_a_sel_o(fwd_a), .fwd_b_sel_o(fwd_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_fwd(input logic w1, input logic [RW-1:0] d1,
                                 input logic w2, input logic [RW-1:0] d2,
                                 input logic [RW-1:0] s);
    if (w1 && d1 != 0 && d1 == s) return 1;
    if (w2 && d2 != 0 && d2 == s) return 2;
    return 0;
  endfunction

  function automatic bit exp_lu(input logic mrd, input logic [RW-1:0] lrt,
                                input logic [RW-1:0] rs, input logic [RW-1:0] rt);
    return mrd && (lrt == rs || lrt == rt);
  endfunction

  task automatic check_all();
    bit hold, fl;
    int ea, eb;
    hold = exp_lu(idex_mem_rd, idex_rt, ifid_rs, ifid_rt) && !br_taken;
    fl   = br_taken;
    chk(hold ? "R1 pc_wr_en" : (fl ? "R9 pc_wr_en" : "R2 pc_wr_en"), pc_wr_en, !hold);
    chk(hold ? "R1 ifid_wr_en" : "R2 ifid_wr_en", ifid_wr_en, !hold);
    chk(fl ? "R9 idex_bubble" : "R1 idex_bubble", idex_bubble, hold || fl);
    chk("R9 ifid_flush", ifid_flush, fl);
    chk("R9 exmem_bubble", exmem_bubble, fl);
    ea = exp_fwd(exmem_reg_wr, exmem_rd, memwb_reg_wr, memwb_rd, idex_rs);
    eb = exp_fwd(exmem_reg_wr, exmem_rd, memwb_reg_wr, memwb_rd, idex_rt);
    chk(ea == 1 ? "R3 fwd_a" : (ea == 2 ? "R4 fwd_a" : "R8 fwd_a"), fwd_a, ea);
    chk("R7 fwd_b", fwd_b, eb);
  endtask

  task automatic drive(input logic [RW-1:0] frs, input logic [RW-1:0] frt,
                       input logic mrd, input logic [RW-1:0] drs, input logic [RW-1:0] drt,
                       input logic ew, input logic [RW-1:0] ed,
                       input logic ww, input logic [RW-1:0] wd, input logic bt);
    @(negedge clk);
    ifid_rs = frs; ifid_rt = frt; idex_mem_rd = mrd; idex_rs = drs; idex_rt = drt;
    exmem_reg_wr = ew; exmem_rd = ed; memwb_reg_wr = ww; memwb_rd = wd; br_taken = bt;
    #1;
  endtask

  // minimal pipeline model: source and destination fields plus two controls
  typedef struct packed {
    logic [RW-1:0] rs;
    logic [RW-1:0] rt;
    logic [RW-1:0] dst;
    logic          mrd;
    logic          wr;
  } ins_t;

  function automatic ins_t prog(input int pc);
    ins_t r = '0;
    case (pc)
      0: r = '{rs: 5'd2, rt: 5'd1, dst: 5'd1, mrd: 1'b1, wr: 1'b1}; // load r1
      1: r = '{rs: 5'd1, rt: 5'd3, dst: 5'd4, mrd: 1'b0, wr: 1'b1}; // r4 = r1 - r3
      2: r = '{rs: 5'd7, rt: 5'd1, dst: 5'd6, mrd: 1'b0, wr: 1'b1};
      3: r = '{rs: 5'd1, rt: 5'd9, dst: 5'd8, mrd: 1'b0, wr: 1'b1};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic run_skeleton();
    ins_t fi = '0, ie = '0, em = '0, mw = '0;
    int pc = 0;
    int stalls = 0;
    for (int step = 1; step <= 8; step++) begin
      mw = em;
      em = exmem_bubble ? '0 : ie;
      ie = idex_bubble ? '0 : fi;
      fi = ifid_flush ? '0 : (ifid_wr_en ? prog(pc) : fi);
      pc = pc_wr_en ? pc + 1 : pc;
      drive(fi.rs, fi.rt, ie.mrd, ie.rs, ie.rt, em.wr, em.dst, mw.wr, mw.dst, 1'b0);
      if (!pc_wr_en) stalls++;
      if (step == 2) chk("R10 stall on dependent load", pc_wr_en, 0);
      if (step == 3) chk("R10 release after one cycle", pc_wr_en, 1);
      if (step == 4) chk("R10 loaded value from write-back", fwd_a, 2);
    end
    chk("R10 total stall cycles", stalls, 1);
    chk("R10 pc after eight steps", pc, 7);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // quiet inputs: no hold, no squash, register-file operands
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 idle pc_wr_en", pc_wr_en, 1);
    chk("R8 idle fwd_a", fwd_a, 0);
    check_all();
    // R1 hit via second source
    drive(4, 9, 1, 0, 9, 0, 0, 0, 0, 0);
    chk("R1 hold via rt", ifid_wr_en, 0);
    // R5 both stages match rs
    drive(0, 0, 0, 6, 2, 1, 6, 1, 6, 0);
    chk("R5 nearer stage wins", fwd_a, 1);
    // R6 register zero with write flag set
    drive(0, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    chk("R6 zero dest a", fwd_a, 0);
    chk("R6 zero dest b", fwd_b, 0);
    // R6 near stage targets r0, far stage real match
    drive(0, 0, 0, 3, 3, 1, 0, 1, 3, 0);
    chk("R6 skip zero use far", fwd_b, 2);
    // R7 distinct sources on both operands
    drive(0, 0, 0, 5, 7, 1, 7, 1, 5, 0);
    chk("R7 fwd_b near", fwd_b, 1);
    chk("R4 fwd_a far", fwd_a, 2);
    // R9 squash coinciding with a hold condition
    drive(3, 3, 1, 0, 3, 0, 0, 0, 0, 1);
    chk("R9 flush beats hold pc", pc_wr_en, 1);
    chk("R9 flush beats hold ifid", ifid_wr_en, 1);
    check_all();
    // constrained random: narrow register range provokes matches
    for (int i = 0; i < 400; i++) begin
      drive($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 4,
            $urandom % 2, $urandom % 4, $urandom % 2, $urandom % 4, ($urandom % 8) == 0);
      check_all();
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_skeleton();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule